// File: doc/BRIEF.md
# Two-Level Vectored Interrupt Controller

This block sits beside a small microcontroller core and decides when and where the core takes an interrupt. It gathers five request sources: two external pins, two timer overflow flags and a serial source that merges transmit-done and receive-done. Software sets a master switch, one enable per source, a high or low level per source, and a trigger mode (falling edge or low level) for each external pin. The block samples its inputs once per machine cycle on a sample strobe from the core.

Requests are examined only in the last cycle of an instruction. Then the block picks one source: high-level requests first, and within a level a fixed order. It raises a call request with the vector address of that source and holds it until the core acknowledges. It keeps one in-service bit per level. A high-level request may interrupt a low-level routine. A low-level request never interrupts a routine, and nothing interrupts a high-level routine. An interrupt-return pulse from the core clears the highest active level. When the instruction that is ending is an interrupt return or an access to the enable or priority register, the core raises a hold-off qualifier, and the poll of that boundary is skipped.

Top module: `irqc_top`

## Requirements
- R1: After reset the enable, priority and type registers read 0 at addresses 0, 1 and 2, and no call is raised. reg_rdata shows the register at reg_addr one cycle later.
- R2: A source is taken only when its enable bit and the global enable (enable bit 7) are both 1. The enable bits are: external 0 bit 0, timer 0 bit 1, external 1 bit 2, timer 1 bit 3, serial bit 4.
- R3: When several sources of the same level are pending, the order from first to last is external 0, timer 0, external 1, timer 1, serial. Their vectors are 0x0003, 0x000B, 0x0013, 0x001B and 0x0023.
- R4: The type register uses bit 0 for external 0 and bit 2 for external 1. A 1 selects falling-edge mode, which latches a flag when two consecutive samples go from 1 to 0. A 0 selects level mode, where a sampled low is the request. Pins are sampled only on cycles where smp_tick is 1.
- R5: An external edge flag clears when its vector is issued. A new falling edge sampled in that same cycle keeps the flag set.
- R6: A poll happens only in a cycle with instr_last=1, instr_holdoff=0 and no call pending. call_req and call_vec hold until call_ack.
- R7: When instr_holdoff is 1 in the last cycle of an instruction, no vector is issued at that boundary. The next instruction boundary polls normally.
- R8: A set bit in the priority register (same bit positions as the enable register) makes that source high level. A high-level request preempts a low-level routine. A low-level request waits while any routine is in service. A high-level routine is never preempted.
- R9: A reti pulse clears the high in-service bit if it is set, and otherwise clears the low in-service bit.
- R10: The serial source requests when ser_tx_done or ser_rx_done was 1 at the last sample.
- R11: When a sample and a poll fall in the same cycle, the poll uses the values from the previous sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 enable, 1 priority, 2 type |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered read data |
| smp_tick | input | 1 | Sampling phase of the machine cycle |
| instr_last | input | 1 | Last cycle of the current instruction |
| instr_holdoff | input | 1 | Instruction ending is a return or an enable/priority access |
| reti | input | 1 | Interrupt-return pulse from the core |
| ext_n | input | 2 | External request pins, active low |
| tmr_ovf | input | 2 | Timer 0 and timer 1 overflow flags |
| ser_tx_done | input | 1 | Serial transmit-done flag |
| ser_rx_done | input | 1 | Serial receive-done flag |
| call_req | output | 1 | Call request to the core |
| call_vec | output | 16 | Vector address of the call |
| call_ack | input | 1 | Core accepts the call |

## Verification
Two pairs of functions can fall in one cycle. The first is a sample strobe and an instruction-boundary poll. The second is the automatic clear of an edge flag on issue and a fresh falling edge on the same pin. The bench drives smp_tick, instr_last and a falling pin in the same cycle. It expects the poll to use the previous sample, and it expects the edge flag set again after it was served, which shows up as a second call at the next boundary. A behavioural model runs beside the design and compares the call outputs and the read data on every clock.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int NSRC    = 5;
  localparam int ADDR_W  = 2;
  localparam int REG_EN  = 0;
  localparam int REG_PRI = 1;
  localparam int REG_TYP = 2;
  localparam int GLB_BIT = 7;
  // source index of each external pin in the tie-break order
  function automatic int ext_src(input int pin);
    return pin * 2;
  endfunction
endpackage

// File: rtl/irqc_ext_sample.sv
module irqc_ext_sample (
  input  logic clk,
  input  logic rst,
  input  logic smp_en,
  input  logic pin_n,
  input  logic edge_mode,
  input  logic clr,
  output logic req
);
  logic lvl_q;
  logic flag_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_q  <= 1'b1;
      flag_q <= 1'b0;
    end else begin
      if (smp_en) lvl_q <= pin_n;
      // a new edge beats the clear from an issue in the same cycle
      if (smp_en && edge_mode && lvl_q && !pin_n) flag_q <= 1'b1;
      else if (clr) flag_q <= 1'b0;
    end
  end

  assign req = edge_mode ? flag_q : ~lvl_q;
endmodule

// File: rtl/irqc_pick.sv
module irqc_pick #(
  parameter int N  = 5,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic          hit,
  output logic [IW-1:0] idx
);
  always_comb begin
    hit = |req;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/irqc_level_track.sv
module irqc_level_track (
  input  logic clk,
  input  logic rst,
  input  logic ret,
  input  logic set_hi,
  input  logic set_lo,
  output logic ins_hi,
  output logic ins_lo
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ins_hi <= 1'b0;
      ins_lo <= 1'b0;
    end else begin
      if (ret) begin
        if (ins_hi) ins_hi <= 1'b0;
        else        ins_lo <= 1'b0;
      end
      if (set_hi) ins_hi <= 1'b1;
      if (set_lo) ins_lo <= 1'b1;
    end
  end
endmodule

// File: rtl/irqc_top.sv
module irqc_top #(
  parameter int VEC_W    = 16,
  parameter int VEC_BASE = 3,
  parameter int VEC_STEP = 8,
  parameter int DATA_W   = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         reg_we,
  input  logic [irqc_pkg::ADDR_W-1:0]  reg_addr,
  input  logic [DATA_W-1:0]            reg_wdata,
  output logic [DATA_W-1:0]            reg_rdata,
  input  logic                         smp_tick,
  input  logic                         instr_last,
  input  logic                         instr_holdoff,
  input  logic                         reti,
  input  logic [1:0]                   ext_n,
  input  logic [1:0]                   tmr_ovf,
  input  logic                         ser_tx_done,
  input  logic                         ser_rx_done,
  output logic                         call_req,
  output logic [VEC_W-1:0]             call_vec,
  input  logic                         call_ack
);
  import irqc_pkg::*;
  localparam int IW = $clog2(NSRC);
  localparam int AW = irqc_pkg::ADDR_W;

  logic [DATA_W-1:0] en_q;
  logic [NSRC-1:0]   pri_q;
  logic [1:0]        typ_q;
  logic [1:0]        tmr_q;
  logic              ser_q;
  logic [1:0]        ext_req;
  logic [NSRC-1:0]   src, pend;
  logic              hi_hit, lo_hit;
  logic [IW-1:0]     hi_idx, lo_idx, sel_idx;
  logic              poll, take_hi, take_lo, issue;
  logic              ins_hi, ins_lo;

  // software registers and read path
  always_ff @(posedge clk) begin
    if (rst) begin
      en_q      <= '0;
      pri_q     <= '0;
      typ_q     <= '0;
      reg_rdata <= '0;
    end else begin
      if (reg_we) begin
        case (reg_addr)
          AW'(REG_EN):  en_q  <= reg_wdata;
          AW'(REG_PRI): pri_q <= reg_wdata[NSRC-1:0];
          AW'(REG_TYP): typ_q <= {reg_wdata[2], reg_wdata[0]};
          default: ;
        endcase
      end
      case (reg_addr)
        AW'(REG_EN):  reg_rdata <= en_q;
        AW'(REG_PRI): reg_rdata <= DATA_W'(pri_q);
        AW'(REG_TYP): reg_rdata <= DATA_W'({typ_q[1], 1'b0, typ_q[0]});
        default:      reg_rdata <= '0;
      endcase
    end
  end

  // sampled peripheral flags
  always_ff @(posedge clk) begin
    if (rst) begin
      tmr_q <= '0;
      ser_q <= 1'b0;
    end else if (smp_tick) begin
      tmr_q <= tmr_ovf;
      ser_q <= ser_tx_done | ser_rx_done;
    end
  end

  for (genvar g = 0; g < 2; g++) begin : g_ext
    irqc_ext_sample u_smp (
      .clk       (clk),
      .rst       (rst),
      .smp_en    (smp_tick),
      .pin_n     (ext_n[g]),
      .edge_mode (typ_q[g]),
      .clr       (issue && (sel_idx == IW'(ext_src(g)))),
      .req       (ext_req[g])
    );
  end

  assign src  = {ser_q, tmr_q[1], ext_req[1], tmr_q[0], ext_req[0]};
  assign pend = src & en_q[NSRC-1:0] & {NSRC{en_q[GLB_BIT]}};

  irqc_pick #(.N(NSRC)) u_pick_hi (.req(pend & pri_q),  .hit(hi_hit), .idx(hi_idx));
  irqc_pick #(.N(NSRC)) u_pick_lo (.req(pend & ~pri_q), .hit(lo_hit), .idx(lo_idx));

  assign poll    = instr_last & ~instr_holdoff & ~call_req;
  assign take_hi = poll & hi_hit & ~ins_hi;
  assign take_lo = poll & ~take_hi & lo_hit & ~ins_hi & ~ins_lo;
  assign issue   = take_hi | take_lo;
  assign sel_idx = take_hi ? hi_idx : lo_idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      call_req <= 1'b0;
      call_vec <= '0;
    end else if (issue) begin
      call_req <= 1'b1;
      call_vec <= VEC_W'(VEC_BASE + VEC_STEP * int'(sel_idx));
    end else if (call_ack) begin
      call_req <= 1'b0;
    end
  end

  irqc_level_track u_lvl (
    .clk    (clk),
    .rst    (rst),
    .ret    (reti),
    .set_hi (take_hi),
    .set_lo (take_lo),
    .ins_hi (ins_hi),
    .ins_lo (ins_lo)
  );
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
  parameter int VEC_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             instr_last,
  input logic             instr_holdoff,
  input logic             reti,
  input logic             call_ack,
  input logic             call_req,
  input logic [VEC_W-1:0] call_vec,
  input logic             glb_en,
  input logic             ins_hi,
  input logic             ins_lo
);
  a_r6_hold_until_ack: assert property (@(posedge clk) disable iff (rst)
    call_req && !call_ack |=> call_req && $stable(call_vec));

  // R6 and R7: a new call only follows an open instruction boundary
  a_r7_no_poll_off_boundary: assert property (@(posedge clk) disable iff (rst)
    !call_req && !(instr_last && !instr_holdoff) |=> !call_req);

  a_r2_global_off: assert property (@(posedge clk) disable iff (rst)
    !glb_en && !call_req |=> !call_req);

  a_r8_high_not_preempted: assert property (@(posedge clk) disable iff (rst)
    ins_hi && !call_req |=> !call_req);

  a_r3_vector_form: assert property (@(posedge clk) disable iff (rst)
    call_req |-> (call_vec[2:0] == 3'd3) && (call_vec < VEC_W'(40)));

  a_r9_ret_clears_high: assert property (@(posedge clk) disable iff (rst)
    reti && ins_hi |=> !ins_hi);

  a_r9_ret_clears_low: assert property (@(posedge clk) disable iff (rst)
    reti && !ins_hi && ins_lo |=> !ins_lo);
endmodule

bind irqc_top irqc_checker #(.VEC_W(VEC_W)) i_chk (
  .clk           (clk),
  .rst           (rst),
  .instr_last    (instr_last),
  .instr_holdoff (instr_holdoff),
  .reti          (reti),
  .call_ack      (call_ack),
  .call_req      (call_req),
  .call_vec      (call_vec),
  .glb_en        (en_q[irqc_pkg::GLB_BIT]),
  .ins_hi        (ins_hi),
  .ins_lo        (ins_lo)
);

// File: tb/test_irqc_top.sv
module test_irqc_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic        smp_tick = 1'b0, instr_last = 1'b0, instr_holdoff = 1'b0, reti = 1'b0;
  logic [1:0]  ext_n = 2'b11;
  logic [1:0]  tmr_ovf = 2'b00;
  logic        ser_tx_done = 1'b0, ser_rx_done = 1'b0;
  logic        call_req;
  logic [15:0] call_vec;
  logic        call_ack = 1'b0;

  int checks = 0, failures = 0, cycles = 0;
  bit done = 1'b0;
  string cur = "R1";

  always #10 clk = ~clk;

  irqc_top i_irqc_top (.*);

  // behavioural reference model
  int m_en, m_pri, m_creq, m_cvec, m_hi, m_lo, m_rd, m_sq;
  int m_typ[2], m_lvl[2], m_flag[2], m_tq[2];

  always @(posedge clk) begin
    int r[5];
    int pick, lvl;
    if (rst) begin
      m_en = 0; m_pri = 0; m_creq = 0; m_cvec = 0; m_hi = 0; m_lo = 0; m_rd = 0; m_sq = 0;
      for (int k = 0; k < 2; k++) begin m_typ[k] = 0; m_lvl[k] = 1; m_flag[k] = 0; m_tq[k] = 0; end
    end else begin
      r[0] = m_typ[0] ? m_flag[0] : (m_lvl[0] == 0);
      r[1] = m_tq[0];
      r[2] = m_typ[1] ? m_flag[1] : (m_lvl[1] == 0);
      r[3] = m_tq[1];
      r[4] = m_sq;
      pick = -1; lvl = 0;
      if (instr_last && !instr_holdoff && !m_creq && m_en[7]) begin
        if (!m_hi)
          for (int i = 0; i < 5; i++)
            if (pick < 0 && r[i] != 0 && m_en[i] && m_pri[i]) begin pick = i; lvl = 2; end
        if (pick < 0 && !m_hi && !m_lo)
          for (int i = 0; i < 5; i++)
            if (pick < 0 && r[i] != 0 && m_en[i] && !m_pri[i]) begin pick = i; lvl = 1; end
      end
      case (reg_addr)
        2'd0: m_rd = m_en;
        2'd1: m_rd = m_pri;
        2'd2: m_rd = m_typ[0] + 4 * m_typ[1];
        default: m_rd = 0;
      endcase
      if (reti) begin if (m_hi) m_hi = 0; else m_lo = 0; end
      if (m_creq && call_ack) m_creq = 0;
      if (pick >= 0) begin
        m_creq = 1; m_cvec = 3 + 8 * pick;
        if (lvl == 2) m_hi = 1; else m_lo = 1;
        if (pick == 0) m_flag[0] = 0;
        if (pick == 2) m_flag[1] = 0;
      end
      if (smp_tick) begin
        for (int k = 0; k < 2; k++) begin
          if (m_typ[k] && m_lvl[k] && !ext_n[k]) m_flag[k] = 1;
          m_lvl[k] = ext_n[k];
        end
        m_tq[0] = tmr_ovf[0]; m_tq[1] = tmr_ovf[1];
        m_sq = ser_tx_done | ser_rx_done;
      end
      if (reg_we) begin
        case (reg_addr)
          2'd0: m_en = reg_wdata;
          2'd1: m_pri = reg_wdata & 8'h1F;
          2'd2: begin m_typ[0] = reg_wdata[0]; m_typ[1] = reg_wdata[2]; end
          default: ;
        endcase
      end
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (!rst && !done) begin
      check(call_req == m_creq[0], {cur, " call_req"}, call_req, m_creq);
      if (call_req) check(call_vec == m_cvec[15:0], {cur, " call_vec"}, call_vec, m_cvec);
      check(reg_rdata == m_rd[7:0], {cur, " rdata"}, reg_rdata, m_rd);
    end
  end

  task automatic wr(input int a, input int d);
    reg_we = 1'b1; reg_addr = a[1:0]; reg_wdata = d[7:0];
    @(negedge clk); reg_we = 1'b0;
  endtask
  task automatic rd(input int a, input int exp, input string tag);
    reg_addr = a[1:0]; @(negedge clk);
    check(reg_rdata == exp[7:0], tag, reg_rdata, exp);
  endtask
  task automatic smp();
    smp_tick = 1'b1; @(negedge clk); smp_tick = 1'b0;
  endtask
  task automatic iend(input bit hold);
    instr_last = 1'b1; instr_holdoff = hold; @(negedge clk);
    instr_last = 1'b0; instr_holdoff = 1'b0;
  endtask
  task automatic ack();
    call_ack = 1'b1; @(negedge clk); call_ack = 1'b0;
  endtask
  task automatic ret();
    reti = 1'b1; instr_last = 1'b1; instr_holdoff = 1'b1; @(negedge clk);
    reti = 1'b0; instr_last = 1'b0; instr_holdoff = 1'b0;
  endtask
  task automatic exp_call(input int v, input string tag);
    check(call_req === 1'b1 && call_vec == v[15:0], tag, call_req ? call_vec : 32'hFFFF, v);
  endtask
  task automatic exp_none(input string tag);
    check(call_req === 1'b0, tag, call_req, 0);
  endtask
  task automatic serve(input int v, input string tag);
    iend(1'b0); exp_call(v, tag); ack(); ret();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    cur = "R1";
    rd(0, 0, "R1 enable reset"); rd(1, 0, "R1 priority reset"); rd(2, 0, "R1 type reset");
    exp_none("R1 no call after reset");
    // R2 enables
    cur = "R2";
    ext_n = 2'b00; tmr_ovf = 2'b11; ser_tx_done = 1'b1; smp();
    iend(1'b0); exp_none("R2 all disabled");
    wr(0, 8'h1F); iend(1'b0); exp_none("R2 global off");
    wr(0, 8'h9F); rd(0, 8'h9F, "R1 enable readback");
    cur = "R7";
    iend(1'b1); exp_none("R7 holdoff boundary");
    // R3 order
    cur = "R3";
    serve(8'h03, "R3 ext0 first");
    serve(8'h03, "R4 level still low");
    wr(0, 8'h9E); serve(8'h0B, "R3 timer0 next");
    wr(0, 8'h9C); serve(8'h13, "R3 ext1 next");
    wr(0, 8'h98); serve(8'h1B, "R3 timer1 next");
    wr(0, 8'h90); serve(8'h23, "R3 serial last");
    // R10 serial OR
    cur = "R10";
    ser_tx_done = 1'b0; ser_rx_done = 1'b1; smp();
    serve(8'h23, "R10 rx only");
    ser_rx_done = 1'b0; smp(); iend(1'b0); exp_none("R10 both clear");
    // R6 poll only at boundary, hold until ack
    cur = "R6";
    wr(0, 8'h81);
    repeat (5) @(negedge clk);
    exp_none("R6 no boundary");
    iend(1'b0); exp_call(8'h03, "R6 call at boundary");
    repeat (3) @(negedge clk);
    exp_call(8'h03, "R6 held until ack");
    iend(1'b0); exp_call(8'h03, "R6 no repoll while pending");
    ack(); exp_none("R6 dropped after ack"); ret();
    // R4 edge mode
    cur = "R4";
    ext_n = 2'b11; smp(); wr(2, 8'h01); rd(2, 8'h01, "R4 type readback");
    iend(1'b0); exp_none("R4 edge idle");
    ext_n[0] = 1'b0; iend(1'b0); exp_none("R4 unsampled edge");
    smp(); ext_n[0] = 1'b1; smp();
    serve(8'h03, "R4 edge served");
    cur = "R5";
    iend(1'b0); exp_none("R5 flag auto cleared");
    ext_n[0] = 1'b0; smp(); ext_n[0] = 1'b1; smp();
    ext_n[0] = 1'b0; smp_tick = 1'b1; instr_last = 1'b1; @(negedge clk);
    smp_tick = 1'b0; instr_last = 1'b0;
    exp_call(8'h03, "R5 issue with new edge"); ack(); ret();
    ext_n[0] = 1'b1; smp();
    serve(8'h03, "R5 new edge kept flag");
    iend(1'b0); exp_none("R5 flag gone");
    // R11 same-cycle sample and poll
    cur = "R11";
    wr(2, 8'h00); ext_n = 2'b11; smp();
    ext_n[0] = 1'b0; smp_tick = 1'b1; instr_last = 1'b1; @(negedge clk);
    smp_tick = 1'b0; instr_last = 1'b0;
    exp_none("R11 poll used old sample");
    serve(8'h03, "R11 next boundary");
    // R8 levels and R9 return
    cur = "R8";
    ext_n = 2'b01; tmr_ovf = 2'b00; smp();
    wr(1, 8'h02); wr(0, 8'h87);
    iend(1'b0); exp_call(8'h13, "R8 low ext1 taken"); ack();
    ext_n = 2'b00; smp(); iend(1'b0); exp_none("R8 low cannot preempt low");
    tmr_ovf = 2'b01; smp(); iend(1'b0); exp_call(8'h0B, "R8 high preempts low"); ack();
    wr(1, 8'h03); iend(1'b0); exp_none("R8 high not preempted");
    cur = "R9";
    ret(); iend(1'b0); exp_call(8'h03, "R9 high cleared first"); ack();
    ret(); wr(1, 8'h02); tmr_ovf = 2'b00; smp();
    iend(1'b0); exp_none("R9 low still in service");
    ret(); iend(1'b0); exp_call(8'h03, "R9 low cleared"); ack(); ret();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1'b1;
      failures++;
      $display("FAIL watchdog actual=%0d expected=<20000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule